// File: doc/BRIEF.md
# SDRAM Command Sequencing Monitor

This block sits beside a two-bank SDRAM command bus and watches it without driving anything. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable pins (qualified by clock-enable) into one command. It keeps an open/closed flag for each bank, a per-bank precharge recovery countdown, a per-bank countdown for bursts that close their bank on their own, and one global countdown that blocks the whole device after mode programming or refresh.

When a command breaks a sequencing rule, the monitor raises an error flag and records a code naming the rule. The flag and the first code stay until reset. The live open/closed state of both banks is also brought out, so a test environment or an on-chip debug path can follow the device. The address pins are used only for the bank-select bit (top address bit) and the auto-precharge / all-banks bit (address bit 10).

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is only seen when cke is 1 and cs_n is 0. Then {ras_n,cas_n,we_n} decodes as 000 mode set, 011 activate, 010 precharge, 101 read, 100 write, 001 refresh. Every other pattern, and any cycle with cs_n high or cke low, is a no-op with no effect.
- R2: After reset both bank_open bits are 0. An activate sets bank_open[addr[11]] from the cycle after it is sampled.
- R3: A precharge with addr[10]=1 clears both bank_open bits. With addr[10]=0 it clears only bank_open[addr[11]]. The change shows in the next cycle.
- R4: A read or write to a bank (addr[11]) whose bank_open bit is 0 gives error code 3.
- R5: An activate to a bank whose bank_open bit is already 1 gives error code 4.
- R6: A mode set or refresh while either bank is open gives error code 2.
- R7: Any non-no-op command sampled 1 to T_MCD cycles after a mode set gives error code 1.
- R8: Any non-no-op command sampled 1 to T_RC cycles after a refresh gives error code 1.
- R9: An activate, read, write or precharge that targets a bank 1 to T_RP cycles after a precharge covering that bank gives error code 5. An all-banks precharge covers both banks.
- R10: A read or write with addr[10]=1 to an open bank clears that bank's bank_open bit BURST_LEN cycles after it is sampled. A later auto-precharge access restarts the count, and a precharge covering the bank cancels it.
- R11: err_flag and err_code are held from the first error until reset, and later errors do not change them. When one command breaks several rules the code follows the order 1, 5, 2, 3, 4.
- R12: During and right after reset, err_flag is 0 and err_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable of the memory bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Address bus; bit 10 is auto-precharge/all-banks, top bit is bank select |
| err_flag | output | 1 | Sticky rule-violation flag |
| err_code | output | 4 | Code of the first violated rule, 0 when none |
| bank_open | output | 2 | Open state of bank 1 and bank 0 |

## Verification
The bench probes the exact edges of each timed window. A command on the last blocked cycle after a mode set, refresh or precharge must be flagged, and one a cycle later must pass. An off-by-one counter would miss the first case or flag the second. It checks that an all-banks precharge puts both banks into recovery, while a single-bank precharge leaves the other bank free to activate. A decoder that ignores address bit 10 would pass one of these and fail the other. It times when an auto-precharge burst closes its bank, checks that a command which breaks two rules reports the higher-priority code, and checks that a later error leaves the first code in place.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_MRS,
    CMD_ACT,
    CMD_PRE,
    CMD_RD,
    CMD_WR,
    CMD_REF
  } cmd_t;

  typedef enum logic [3:0] {
    ERR_NONE        = 4'd0,
    ERR_WINDOW      = 4'd1,
    ERR_BANKS_BUSY  = 4'd2,
    ERR_IDLE_ACCESS = 4'd3,
    ERR_DOUBLE_ACT  = 4'd4,
    ERR_RECOVERY    = 4'd5
  } err_code_t;

endpackage

// File: rtl/sdcm_decode.sv
module sdcm_decode
  import sdcm_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_t cmd_o
);

  always_comb begin
    cmd_o = CMD_NOP;
    if (cke && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  cmd_o = CMD_MRS;
        3'b011:  cmd_o = CMD_ACT;
        3'b010:  cmd_o = CMD_PRE;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b001:  cmd_o = CMD_REF;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdcm_bank.sv
module sdcm_bank
  import sdcm_pkg::*;
#(
  parameter int BANK_SEL  = 0,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd_i,
  input  logic ap_i,
  input  logic ba_i,
  output logic hit_o,
  output logic open_o,
  output logic rp_busy_o
);

  localparam int RP_W = $clog2(T_RP + 1);
  localparam int BC_W = $clog2(BURST_LEN + 1);

  logic            open_q, open_d;
  logic [RP_W-1:0] rp_q, rp_d;
  logic [BC_W-1:0] bc_q, bc_d;
  logic            sel, pre_hit, acc_hit, act_hit;

  assign sel     = (ba_i == 1'(BANK_SEL));
  assign act_hit = (cmd_i == CMD_ACT) && sel;
  assign acc_hit = ((cmd_i == CMD_RD) || (cmd_i == CMD_WR)) && sel;
  assign pre_hit = (cmd_i == CMD_PRE) && (ap_i || sel);
  assign hit_o   = act_hit || acc_hit || pre_hit;

  always_comb begin
    open_d = open_q;
    rp_d   = rp_q;
    bc_d   = bc_q;
    if (rp_q != '0) rp_d = rp_q - 1'b1;
    if (bc_q != '0) bc_d = bc_q - 1'b1;
    if (bc_q == BC_W'(1)) open_d = 1'b0;
    if (act_hit) begin
      open_d = 1'b1;
    end else if (pre_hit) begin
      open_d = 1'b0;
      rp_d   = RP_W'(T_RP);
      bc_d   = '0;
    end else if (acc_hit && ap_i && open_q) begin
      bc_d   = BC_W'(BURST_LEN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rp_q   <= '0;
      bc_q   <= '0;
    end else begin
      open_q <= open_d;
      rp_q   <= rp_d;
      bc_q   <= bc_d;
    end
  end

  assign open_o    = open_q;
  assign rp_busy_o = (rp_q != '0);

endmodule

// File: rtl/sdcm_window.sv
module sdcm_window
  import sdcm_pkg::*;
#(
  parameter int T_MCD = 2,
  parameter int T_RC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd_i,
  output logic busy_o
);

  localparam int MAXW = (T_MCD > T_RC) ? T_MCD : T_RC;
  localparam int W_W  = $clog2(MAXW + 1);

  logic [W_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    if (cmd_i == CMD_MRS)      cnt_d = W_W'(T_MCD);
    else if (cmd_i == CMD_REF) cnt_d = W_W'(T_RC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdcm_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int T_MCD     = 2,
  parameter int T_RC      = 4,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              err_flag,
  output logic [3:0]        err_code,
  output logic [1:0]        bank_open
);

  localparam int NUM_BANKS = 2;
  localparam int BA_BIT    = ADDR_W - 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  cmd_t cmd;
  logic ap, ba;
  logic unused_addr;

  assign ap          = addr[AP_BIT];
  assign ba          = addr[BA_BIT];
  assign unused_addr = ^{addr[AP_BIT-1:0], addr[BA_BIT-1:AP_BIT+1]};

  sdcm_decode u_dec (
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd_o (cmd)
  );

  logic [NUM_BANKS-1:0] hit, open, rp_busy;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdcm_bank #(
      .BANK_SEL  (b),
      .T_RP      (T_RP),
      .BURST_LEN (BURST_LEN)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .cmd_i     (cmd),
      .ap_i      (ap),
      .ba_i      (ba),
      .hit_o     (hit[b]),
      .open_o    (open[b]),
      .rp_busy_o (rp_busy[b])
    );
  end

  logic win_busy;

  sdcm_window #(
    .T_MCD (T_MCD),
    .T_RC  (T_RC)
  ) u_win (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cmd_i  (cmd),
    .busy_o (win_busy)
  );

  // rule evaluation, fixed priority
  err_code_t code_d;
  logic      is_global, is_access;

  assign is_global = (cmd == CMD_MRS) || (cmd == CMD_REF);
  assign is_access = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_comb begin
    code_d = ERR_NONE;
    if ((cmd != CMD_NOP) && win_busy)        code_d = ERR_WINDOW;
    else if (|(hit & rp_busy))               code_d = ERR_RECOVERY;
    else if (is_global && (|open))           code_d = ERR_BANKS_BUSY;
    else if (is_access && (|(hit & ~open)))  code_d = ERR_IDLE_ACCESS;
    else if ((cmd == CMD_ACT) && (|(hit & open))) code_d = ERR_DOUBLE_ACT;
  end

  logic      flag_q, err_en;
  err_code_t code_q;

  assign err_en = !flag_q && (code_d != ERR_NONE);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flag_q <= 1'b0;
      code_q <= ERR_NONE;
    end else if (err_en) begin
      flag_q <= 1'b1;
      code_q <= code_d;
    end
  end

  assign err_flag  = flag_q;
  assign err_code  = code_q;
  assign bank_open = open;

endmodule

// File: rtl/sdcm_checker.sv
module sdcm_checker #(
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              err_flag,
  input logic [3:0]        err_code,
  input logic [1:0]        bank_open
);

  logic live, ap, ba, p_act, p_pre, p_acc, p_glb;
  logic unused_bits;

  assign live  = cke && !cs_n;
  assign ap    = addr[AP_BIT];
  assign ba    = addr[ADDR_W-1];
  assign p_act = live && ({ras_n, cas_n, we_n} == 3'b011);
  assign p_pre = live && ({ras_n, cas_n, we_n} == 3'b010);
  assign p_acc = live && (({ras_n, cas_n, we_n} == 3'b101) || ({ras_n, cas_n, we_n} == 3'b100));
  assign p_glb = live && (({ras_n, cas_n, we_n} == 3'b000) || ({ras_n, cas_n, we_n} == 3'b001));
  assign unused_bits = ^{addr[AP_BIT-1:0], addr[ADDR_W-2:AP_BIT+1]};

  AST_ACT_OPENS_B0: assert property (@(posedge clk) disable iff (!rst_n)
    (p_act && !ba) |=> bank_open[0]); // R2
  AST_ACT_OPENS_B1: assert property (@(posedge clk) disable iff (!rst_n)
    (p_act && ba) |=> bank_open[1]); // R2
  AST_PRE_CLOSES_B0: assert property (@(posedge clk) disable iff (!rst_n)
    (p_pre && (ap || !ba)) |=> !bank_open[0]); // R3
  AST_PRE_CLOSES_B1: assert property (@(posedge clk) disable iff (!rst_n)
    (p_pre && (ap || ba)) |=> !bank_open[1]); // R3
  AST_IDLE_ACCESS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (p_acc && !bank_open[ba]) |=> err_flag); // R4
  AST_GLOBAL_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (p_glb && (|bank_open)) |=> err_flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R11
  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> $stable(err_code)); // R11
  AST_FLAG_CODE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag == (err_code != 4'd0)); // R12

endmodule

bind sdram_cmd_monitor sdcm_checker #(
  .ADDR_W (ADDR_W),
  .AP_BIT (AP_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .addr      (addr),
  .err_flag  (err_flag),
  .err_code  (err_code),
  .bank_open (bank_open)
);

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;

  localparam int ADDR_W = 12;
  localparam int T_MCD = 2, T_RC = 4, T_RP = 3, BURST_LEN = 4;
  localparam int C_NOP = 0, C_MRS = 1, C_ACT = 2, C_PRE = 3, C_RD = 4, C_WR = 5, C_REF = 6;

  logic clk, rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [ADDR_W-1:0] addr;
  logic err_flag;
  logic [3:0] err_code;
  logic [1:0] bank_open;

  sdram_cmd_monitor #(
    .ADDR_W(ADDR_W), .AP_BIT(10), .T_MCD(T_MCD), .T_RC(T_RC),
    .T_RP(T_RP), .BURST_LEN(BURST_LEN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .err_flag(err_flag),
    .err_code(err_code), .bank_open(bank_open)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit m_open[2];
  int m_rp[2], m_bc[2], m_win, m_code;
  bit m_flag;

  task automatic check(string tag, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int decode(bit k, bit cs, bit r, bit c, bit w);
    if (!k || cs) return C_NOP;
    case ({r, c, w})
      3'b000: return C_MRS;
      3'b011: return C_ACT;
      3'b010: return C_PRE;
      3'b101: return C_RD;
      3'b100: return C_WR;
      3'b001: return C_REF;
      default: return C_NOP;
    endcase
  endfunction

  function automatic void model_reset();
    for (int b = 0; b < 2; b++) begin
      m_open[b] = 0; m_rp[b] = 0; m_bc[b] = 0;
    end
    m_win = 0; m_flag = 0; m_code = 0;
  endfunction

  function automatic void model_step(int c, bit a10, bit a11);
    bit h[2];
    int code = 0;
    bit rp_hit = 0, idle_hit = 0, open_hit = 0;
    for (int b = 0; b < 2; b++) begin
      h[b] = ((c == C_ACT || c == C_RD || c == C_WR) && (a11 == b[0])) ||
             (c == C_PRE && (a10 || a11 == b[0]));
      if (h[b] && m_rp[b] > 0) rp_hit = 1;
      if (h[b] && !m_open[b]) idle_hit = 1;
      if (h[b] && m_open[b]) open_hit = 1;
    end
    if (c != C_NOP && m_win > 0) code = 1;
    else if (rp_hit) code = 5;
    else if ((c == C_MRS || c == C_REF) && (m_open[0] || m_open[1])) code = 2;
    else if ((c == C_RD || c == C_WR) && idle_hit) code = 3;
    else if (c == C_ACT && open_hit) code = 4;
    if (!m_flag && code != 0) begin m_flag = 1; m_code = code; end
    for (int b = 0; b < 2; b++) begin
      bit was_open = m_open[b];
      if (m_rp[b] > 0) m_rp[b]--;
      if (m_bc[b] == 1) m_open[b] = 0;
      if (m_bc[b] > 0) m_bc[b]--;
      if (h[b] && c == C_ACT) m_open[b] = 1;
      else if (h[b] && c == C_PRE) begin m_open[b] = 0; m_rp[b] = T_RP; m_bc[b] = 0; end
      else if (h[b] && a10 && was_open && (c == C_RD || c == C_WR)) m_bc[b] = BURST_LEN;
    end
    if (m_win > 0) m_win--;
    if (c == C_MRS) m_win = T_MCD;
    else if (c == C_REF) m_win = T_RC;
  endfunction

  task automatic step(int c, bit a10 = 0, bit a11 = 0, bit k = 1, bit csh = 0);
    logic [2:0] p;
    case (c)
      C_MRS: p = 3'b000;
      C_ACT: p = 3'b011;
      C_PRE: p = 3'b010;
      C_RD:  p = 3'b101;
      C_WR:  p = 3'b100;
      C_REF: p = 3'b001;
      default: p = 3'b111;
    endcase
    {ras_n, cas_n, we_n} = p;
    cke = k; cs_n = csh;
    addr = ADDR_W'($urandom);
    addr[10] = a10; addr[ADDR_W-1] = a11;
    model_step(decode(cke, cs_n, ras_n, cas_n, we_n), a10, a11);
    @(posedge clk); #1;
    check("R11 err_flag vs model", int'(err_flag), int'(m_flag));
    check("R11 err_code vs model", int'(err_code), m_code);
    check("R2 bank_open vs model", int'(bank_open), int'({m_open[1], m_open[0]}));
  endtask

  task automatic do_reset();
    rst_n = 0; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; addr = '0;
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    check("R12 flag in reset", int'(err_flag), 0);
    check("R12 code in reset", int'(err_code), 0);
    check("R2 banks closed in reset", int'(bank_open), 0);
    rst_n = 1;
    repeat (3) step(C_NOP);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R2, R5
    step(C_ACT, 0, 0); step(C_ACT, 0, 1);
    check("R2 both open", int'(bank_open), 3);
    check("R2 no error", int'(err_flag), 0);
    step(C_ACT, 0, 0);
    check("R5 double activate code", int'(err_code), 4);

    // R4 and R11 sticky
    do_reset();
    step(C_ACT, 0, 1); step(C_RD, 0, 0);
    check("R4 idle read code", int'(err_code), 3);
    step(C_MRS);
    check("R11 code held after later error", int'(err_code), 3);
    check("R11 flag held", int'(err_flag), 1);

    // R6
    do_reset();
    step(C_ACT, 0, 0); step(C_REF);
    check("R6 refresh while open", int'(err_code), 2);

    // R7 window boundaries
    do_reset();
    step(C_MRS); step(C_NOP); step(C_NOP); step(C_ACT, 0, 0);
    check("R7 after mode window ok", int'(err_flag), 0);
    do_reset();
    step(C_MRS); step(C_NOP); step(C_ACT, 0, 0);
    check("R7 last blocked cycle", int'(err_code), 1);

    // R8 window boundaries
    do_reset();
    step(C_REF); repeat (4) step(C_NOP); step(C_ACT, 0, 1);
    check("R8 after refresh window ok", int'(err_flag), 0);
    do_reset();
    step(C_REF); repeat (3) step(C_NOP); step(C_WR, 0, 1);
    check("R8 last blocked cycle", int'(err_code), 1);

    // R3, R9 all-banks precharge
    do_reset();
    step(C_ACT, 0, 0); step(C_ACT, 0, 1); step(C_PRE, 1, 0);
    check("R3 all-banks close", int'(bank_open), 0);
    step(C_NOP); step(C_ACT, 0, 1);
    check("R9 other bank in recovery", int'(err_code), 5);

    // R3, R9 single-bank precharge, boundary
    do_reset();
    step(C_ACT, 0, 0); step(C_PRE, 0, 0); step(C_ACT, 0, 1);
    check("R3 single-bank leaves other free", int'(bank_open), 2);
    check("R9 other bank not blocked", int'(err_flag), 0);
    step(C_NOP); step(C_NOP); step(C_ACT, 0, 0);
    check("R9 recovery over", int'(err_flag), 0);
    check("R2 both open again", int'(bank_open), 3);

    // R11 priority: recovery beats idle access
    do_reset();
    step(C_ACT, 0, 0); step(C_PRE, 0, 0); step(C_RD, 0, 0);
    check("R11 priority code 5 over 3", int'(err_code), 5);

    // R10 auto-precharge timing
    do_reset();
    step(C_ACT, 0, 1); step(C_WR, 1, 1);
    repeat (BURST_LEN - 1) step(C_NOP);
    check("R10 still open before burst end", int'(bank_open), 2);
    step(C_NOP);
    check("R10 closed at burst end", int'(bank_open), 0);
    check("R10 no error", int'(err_flag), 0);

    // R1 gating
    do_reset();
    step(C_ACT, 0, 0, 0, 0);
    check("R1 cke low ignored", int'(bank_open), 0);
    step(C_ACT, 0, 1, 1, 1);
    check("R1 cs_n high ignored", int'(bank_open), 0);
    check("R1 no error", int'(err_flag), 0);

    // random segments
    for (int s = 0; s < 40; s++) begin
      do_reset();
      for (int i = 0; i < 60; i++) begin
        int r = $urandom_range(0, 11);
        int c;
        case (r)
          4, 5: c = C_ACT;
          6:    c = C_PRE;
          7:    c = C_RD;
          8:    c = C_WR;
          9:    c = ($urandom_range(0, 3) == 0) ? C_MRS : C_NOP;
          10:   c = ($urandom_range(0, 3) == 0) ? C_REF : C_NOP;
          default: c = C_NOP;
        endcase
        step(c, 1'($urandom), 1'($urandom), ($urandom_range(0, 9) != 0),
             ($urandom_range(0, 9) == 0));
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule